// File: doc/BRIEF.md
# Aliased Multi-Width Register File

This block holds the general registers of a processor core in a single storage array and exposes that array at three access widths. The storage is eight 32-bit registers. Each register splits into an upper extended half and a lower base half, which gives sixteen 16-bit views. Each base half splits again into a high byte and a low byte, which gives sixteen 8-bit views. Every access, at any width, resolves against the same bits.

The block has two read ports and one write port. Each port takes a 4-bit selector and a 2-bit size code. A write changes only the bytes that its size and selector cover. Read data is registered and appears one clock after the request. The returned value is the register contents after any write in the same cycle, so a read that overlaps a write returns the new bytes merged with the bytes the write left alone. Byte and word results are zero-extended to 32 bits.

Top module: `alias_regfile`

## Requirements
- R1: A cycle with `rst` high clears every register to zero and clears both read outputs. After that, every read returns zero until a write takes place.
- R2: Size code 2'b10 (long) reads or writes all 32 bits of the register chosen by selector bits 2:0. Selector bit 3 has no effect on a long access.
- R3: Size code 2'b01 (word) with selector bit 3 = 1 reads bits 31:16 (the extended half). With bit 3 = 0 it reads bits 15:0 (the base half). The result is zero-extended in bits 31:16 of the output.
- R4: Size code 2'b00 (byte) with selector bit 3 = 1 reads bits 7:0 (the low byte). With bit 3 = 0 it reads bits 15:8 (the high byte). The result is zero-extended in bits 31:8 of the output.
- R5: A byte write stores `wr_data[7:0]` into the addressed byte and leaves the other 24 bits of that register unchanged.
- R6: A word write stores `wr_data[15:0]` into the addressed half and leaves the other half unchanged.
- R7: Read data appears on the clock edge after the request. It equals the register contents with any write of the same cycle already applied, including a partial overlap.
- R8: Size code 2'b11 is reserved. A write with this code changes nothing, and a read with this code returns zero.
- R9: The two read ports work independently. Each port may address any register at any size in the same cycle.
- R10: When `wr_en` is low, no register changes, whatever values the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_sel | input | 4 | Write selector: bit 3 chooses the view, bits 2:0 the register |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data, right-aligned for byte and word writes |
| rd0_sel | input | 4 | Read port 0 selector |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 data, registered, zero-extended |
| rd1_sel | input | 4 | Read port 1 selector |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 data, registered, zero-extended |

## Verification
A corrupted byte lane or a wrong lane-enable decode stays hidden until some port reads the affected bytes. It then appears on that read's output one clock later, either as a neighbour byte that should have survived a partial write or as a stale value in place of the new one. The bench therefore follows narrow writes with wide reads, and wide writes with narrow reads, on both ports, so that a lane error shows up on the next read of that register. Reads issued in the same cycle as an overlapping write expose a missing or partial bypass on the very next edge.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSV  = 2'b11
  } rf_size_e;

  localparam int unsigned RF_LANES = 4;
endpackage

// File: rtl/rf_wr_align.sv
`timescale 1ns/1ps
// Turns a write request into per-lane enables and lane-replicated data.
module rf_wr_align
  import rf_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic                                  wr_en,
  input  logic [$clog2(NREG):0]                 wr_sel,
  input  logic [1:0]                            wr_size,
  input  logic [RF_LANES*LANE_W-1:0]            wr_data,
  output logic [$clog2(NREG)-1:0]               wr_idx,
  output logic [RF_LANES-1:0]                   lane_we,
  output logic [RF_LANES*LANE_W-1:0]            lane_wdata
);
  localparam int unsigned IDX_W  = $clog2(NREG);
  localparam int unsigned WORD_W = 2 * LANE_W;

  rf_size_e sz;
  logic     view_hi;

  assign sz      = rf_size_e'(wr_size);
  assign view_hi = wr_sel[IDX_W];
  assign wr_idx  = wr_sel[IDX_W-1:0];

  always_comb begin
    lane_we    = '0;
    lane_wdata = '0;
    case (sz)
      SZ_BYTE: begin
        lane_wdata = {RF_LANES{wr_data[LANE_W-1:0]}};
        lane_we    = view_hi ? 4'b0001 : 4'b0010;
      end
      SZ_WORD: begin
        lane_wdata = {2{wr_data[WORD_W-1:0]}};
        lane_we    = view_hi ? 4'b1100 : 4'b0011;
      end
      SZ_LONG: begin
        lane_wdata = wr_data;
        lane_we    = 4'b1111;
      end
      default: begin
        lane_we    = '0;
        lane_wdata = '0;
      end
    endcase
    if (!wr_en) lane_we = '0;
  end
endmodule

// File: rtl/rf_lane.sv
`timescale 1ns/1ps
// One byte lane of the register file: NREG entries, one write, two bypassed reads.
module rf_lane #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] widx,
  input  logic [LANE_W-1:0]       wdata,
  input  logic [$clog2(NREG)-1:0] ridx0,
  input  logic [$clog2(NREG)-1:0] ridx1,
  output logic [LANE_W-1:0]       rdata0,
  output logic [LANE_W-1:0]       rdata1
);
  logic [NREG-1:0][LANE_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  // Same-cycle write is merged into the read so the registered output sees it.
  always_comb begin
    rdata0 = (we && widx == ridx0) ? wdata : mem[ridx0];
    rdata1 = (we && widx == ridx1) ? wdata : mem[ridx1];
  end

  // R10: a lane without a write enable keeps every entry.
  p_lane_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!rst && !we) |=> $stable(mem));
endmodule

// File: rtl/rf_rd_format.sv
`timescale 1ns/1ps
// Selects the requested view out of a merged 32-bit register and zero-extends it.
module rf_rd_format
  import rf_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic                       view_hi,
  input  logic [1:0]                 size,
  input  logic [RF_LANES*LANE_W-1:0] raw,
  output logic [RF_LANES*LANE_W-1:0] view
);
  localparam int unsigned WORD_W = 2 * LANE_W;
  localparam int unsigned LONG_W = RF_LANES * LANE_W;

  always_comb begin
    view = '0;
    case (rf_size_e'(size))
      SZ_BYTE: view[LANE_W-1:0] = view_hi ? raw[LANE_W-1:0] : raw[WORD_W-1:LANE_W];
      SZ_WORD: view[WORD_W-1:0] = view_hi ? raw[LONG_W-1:WORD_W] : raw[WORD_W-1:0];
      SZ_LONG: view = raw;
      default: view = '0;
    endcase
  end

  always_comb begin
    if (rf_size_e'(size) == SZ_BYTE)
      p_byte_zext_r4: assert (view[LONG_W-1:LANE_W] == '0);
    if (rf_size_e'(size) == SZ_WORD)
      p_word_zext_r3: assert (view[LONG_W-1:WORD_W] == '0);
  end
endmodule

// File: rtl/alias_regfile.sv
`timescale 1ns/1ps
// Register file with byte, word and long views over one storage array.
module alias_regfile
  import rf_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [1:0]  wr_size,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd0_sel,
  input  logic [1:0]  rd0_size,
  output logic [31:0] rd0_data,
  input  logic [3:0]  rd1_sel,
  input  logic [1:0]  rd1_size,
  output logic [31:0] rd1_data
);
  localparam int unsigned IDX_W  = $clog2(NREG);
  localparam int unsigned LONG_W = RF_LANES * LANE_W;

  logic [IDX_W-1:0]    wr_idx;
  logic [RF_LANES-1:0] lane_we;
  logic [LONG_W-1:0]   lane_wdata;
  logic [LONG_W-1:0]   raw0, raw1;
  logic [LONG_W-1:0]   view0, view1;
  logic [LONG_W-1:0]   rd0_q, rd1_q;

  rf_wr_align #(.NREG(NREG), .LANE_W(LANE_W)) u_align (
    .wr_en      (wr_en),
    .wr_sel     (wr_sel[IDX_W:0]),
    .wr_size    (wr_size),
    .wr_data    (wr_data[LONG_W-1:0]),
    .wr_idx     (wr_idx),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata)
  );

  for (genvar l = 0; l < RF_LANES; l++) begin : g_lane
    rf_lane #(.NREG(NREG), .LANE_W(LANE_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .we     (lane_we[l]),
      .widx   (wr_idx),
      .wdata  (lane_wdata[l*LANE_W +: LANE_W]),
      .ridx0  (rd0_sel[IDX_W-1:0]),
      .ridx1  (rd1_sel[IDX_W-1:0]),
      .rdata0 (raw0[l*LANE_W +: LANE_W]),
      .rdata1 (raw1[l*LANE_W +: LANE_W])
    );
  end

  rf_rd_format #(.LANE_W(LANE_W)) u_fmt0 (
    .view_hi (rd0_sel[IDX_W]),
    .size    (rd0_size),
    .raw     (raw0),
    .view    (view0)
  );

  rf_rd_format #(.LANE_W(LANE_W)) u_fmt1 (
    .view_hi (rd1_sel[IDX_W]),
    .size    (rd1_size),
    .raw     (raw1),
    .view    (view1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0_q <= '0;
      rd1_q <= '0;
    end else begin
      rd0_q <= view0;
      rd1_q <= view1;
    end
  end

  assign rd0_data = rd0_q;
  assign rd1_data = rd1_q;

  // R1: reset leaves both outputs at zero.
  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (rd0_data == '0 && rd1_data == '0));

  // R5: an enabled byte write touches exactly one lane.
  p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b00) |-> $countones(lane_we) == 1);

  // R6: an enabled word write touches exactly two lanes.
  p_word_two_lanes_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b01) |-> $countones(lane_we) == 2);

  // R8: the reserved size code never enables a lane.
  p_rsv_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_size == 2'b11) |-> lane_we == '0);

  // R8: a reserved-size read returns zero one cycle later.
  p_rsv_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd0_size) == 2'b11) |-> rd0_data == '0);

  // R7 and R2: a long read of the register being long-written returns the new data.
  p_long_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_size) == 2'b10 && $past(rd0_size) == 2'b10
     && $past(wr_sel[IDX_W-1:0]) == $past(rd0_sel[IDX_W-1:0]))
    |-> rd0_data == $past(wr_data));
endmodule

// File: tb/tb_alias_regfile.sv
`timescale 1ns/1ps
module tb_alias_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd0_sel = '0;
  logic [1:0]  rd0_size = '0;
  logic [31:0] rd0_data;
  logic [3:0]  rd1_sel = '0;
  logic [1:0]  rd1_size = '0;
  logic [31:0] rd1_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] mdl [8];

  always #5 clk = ~clk;

  alias_regfile dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
    .wr_data(wr_data), .rd0_sel(rd0_sel), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_sel(rd1_sel), .rd1_size(rd1_size), .rd1_data(rd1_data)
  );

  function automatic void mdl_write(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
    case (z)
      2'b00: if (s[3]) mdl[s[2:0]][7:0] = d[7:0]; else mdl[s[2:0]][15:8] = d[7:0];
      2'b01: if (s[3]) mdl[s[2:0]][31:16] = d[15:0]; else mdl[s[2:0]][15:0] = d[15:0];
      2'b10: mdl[s[2:0]] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] mdl_read(input logic [3:0] s, input logic [1:0] z);
    logic [31:0] r = mdl[s[2:0]];
    case (z)
      2'b00: return s[3] ? {24'h0, r[7:0]} : {24'h0, r[15:8]};
      2'b01: return s[3] ? {16'h0, r[31:16]} : {16'h0, r[15:0]};
      2'b10: return r;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input string port, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] ws, input logic [1:0] wz, input logic [31:0] wd,
                      input logic [3:0] s0, input logic [1:0] z0,
                      input logic [3:0] s1, input logic [1:0] z1, input string tag);
    wr_en = we; wr_sel = ws; wr_size = wz; wr_data = wd;
    rd0_sel = s0; rd0_size = z0; rd1_sel = s1; rd1_size = z1;
    @(posedge clk);
    #1;
    if (we) mdl_write(ws, wz, wd);
    check(tag, "rd0", rd0_data, mdl_read(s0, z0));
    check(tag, "rd1", rd1_data, mdl_read(s1, z1));
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s0, input logic [1:0] z0,
                    input logic [3:0] s1, input logic [1:0] z1, input string tag);
    step(1'b0, 4'h0, 2'b00, 32'h0, s0, z0, s1, z1, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    // Dirty write request during reset must not land.
    wr_en = 1'b1; wr_sel = 4'h2; wr_size = 2'b10; wr_data = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0; wr_en = 1'b0;
    check("R1", "rd0", rd0_data, 32'h0);
    check("R1", "rd1", rd1_data, 32'h0);
    for (int i = 0; i < 8; i++) rd(4'(i), 2'b10, 4'(i + 8), 2'b10, "R1");

    // R2: long write with bit 3 set, read with bit 3 clear and set.
    step(1'b1, 4'hB, 2'b10, 32'h1122_3344, 4'h0, 2'b10, 4'h0, 2'b10, "R2");
    rd(4'h3, 2'b10, 4'hB, 2'b10, "R2");
    // R3: word views of register 3.
    rd(4'hB, 2'b01, 4'h3, 2'b01, "R3");
    // R4: byte views of register 3.
    rd(4'hB, 2'b00, 4'h3, 2'b00, "R4");
    // R5: byte writes keep the rest of the register.
    step(1'b1, 4'hB, 2'b00, 32'hFFFF_FFAA, 4'h3, 2'b10, 4'h3, 2'b00, "R5");
    step(1'b1, 4'h3, 2'b00, 32'h0000_0055, 4'h3, 2'b10, 4'hB, 2'b00, "R5");
    // R6: word writes keep the other half.
    step(1'b1, 4'hB, 2'b01, 32'hABCD_9876, 4'h3, 2'b10, 4'h3, 2'b01, "R6");
    step(1'b1, 4'h3, 2'b01, 32'h0000_C0DE, 4'h3, 2'b10, 4'hB, 2'b01, "R6");
    // R7: same-cycle overlap returns merged new bytes on both ports.
    step(1'b1, 4'h5, 2'b10, 32'hCAFE_F00D, 4'h5, 2'b10, 4'hD, 2'b01, "R7");
    step(1'b1, 4'hD, 2'b00, 32'h0000_0011, 4'h5, 2'b10, 4'h5, 2'b00, "R7");
    step(1'b1, 4'h5, 2'b01, 32'h0000_7777, 4'hD, 2'b10, 4'h5, 2'b00, "R7");
    // R8: reserved size writes nothing and reads zero.
    step(1'b1, 4'h5, 2'b11, 32'hFFFF_FFFF, 4'h5, 2'b10, 4'h5, 2'b11, "R8");
    rd(4'h5, 2'b11, 4'hD, 2'b10, "R8");
    // R9: different registers and sizes on the two ports.
    step(1'b1, 4'h7, 2'b10, 32'h0102_0304, 4'h7, 2'b00, 4'h3, 2'b10, "R9");
    // R10: write inputs toggled with wr_en low change nothing.
    wr_en = 1'b0; wr_sel = 4'h7; wr_size = 2'b10; wr_data = 32'hFFFF_0000;
    rd0_sel = 4'h7; rd0_size = 2'b10; rd1_sel = 4'hF; rd1_size = 2'b01;
    @(posedge clk); #1;
    check("R10", "rd0", rd0_data, mdl_read(4'h7, 2'b10));
    check("R10", "rd1", rd1_data, mdl_read(4'hF, 2'b01));

    // Random mix of all sizes, views and overlaps.
    for (int n = 0; n < 600; n++) begin
      step(1'($urandom), 4'($urandom), 2'($urandom), $urandom,
           4'($urandom), 2'($urandom), 4'($urandom), 2'($urandom), "R7");
    end
    for (int i = 0; i < 8; i++) rd(4'(i), 2'b10, 4'(i), 2'b00, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule